// File: doc/BRIEF.md
# Memory Request Handshake Controller

This controller sits between a requester and a single-port memory and turns one read or one write request into a short, fixed sequence of control strobes. While idle it watches two request lines. When a request appears it pulses an address-capture strobe in that same cycle. It then steps through a fixed sequence and raises a one-cycle completion strobe. After that it returns to idle. A write request beats a read request that arrives in the same cycle.

A read finishes one cycle after the capture cycle. A write passes through two states and finishes two cycles after capture. The direction output stays high, meaning read, at all times except the last write cycle, where it drops low to tell the memory to store. The requester keeps its request asserted until it sees the completion strobe. Requests that arrive while a transaction is in flight have no effect. A synchronous reset input returns the machine to idle. While reset is high, the outputs are forced to their quiet values.

The state register can be built with a dense two-bit code or with a one-hot code, chosen by a parameter. The port behaviour is the same for both.

Top module: `mem_hs_ctl`

## Requirements
- R1: After a cycle with rst high and with no request pending, the outputs are addr_cap=0, rd_nwr=1, done=0.
- R2: While rst is high, the outputs are addr_cap=0, rd_nwr=1, done=0 in every state and for any request inputs. The cycle after rst was high, the machine is idle.
- R3: When idle with rst low and neither request asserted, the machine stays idle and the outputs stay at addr_cap=0, rd_nwr=1, done=0.
- R4: When idle with req_wr=1, whatever req_rd is, the same cycle shows addr_cap=1, rd_nwr=1, done=0, and the machine enters the first write state. A write wins over a simultaneous read.
- R5: When idle with req_wr=0 and req_rd=1, the same cycle shows addr_cap=1, rd_nwr=1, done=0. The next cycle shows addr_cap=0, rd_nwr=1, done=1, and the cycle after that is idle.
- R6: The cycle after a write capture shows addr_cap=0, rd_nwr=1, done=0. The cycle after that shows addr_cap=0, rd_nwr=0, done=1, and the machine is then idle.
- R7: rd_nwr is low only in the final write cycle. rd_nwr=1 means read and rd_nwr=0 means write.
- R8: Outside idle, req_wr and req_rd have no effect on the outputs or on the sequence, and addr_cap stays 0.
- R9: done is high for exactly one cycle per transaction. Counting the request cycle as cycle 1, a read raises done in cycle 2 and a write raises done in cycle 3.
- R10: With parameter ONE_HOT=1, the state register holds exactly one set bit and the port behaviour is identical to ONE_HOT=0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high; forces quiet outputs |
| req_wr | input | 1 | Write request, held until done |
| req_rd | input | 1 | Read request, held until done |
| addr_cap | output | 1 | Address capture strobe, high in the accepting idle cycle |
| rd_nwr | output | 1 | Direction: 1 = read, 0 = write (low only in the final write cycle) |
| done | output | 1 | One-cycle completion strobe |

## Verification
The assertions assume that reset is held high across the first clock edge, so that the state register starts from idle. They also assume that request lines change only between clock edges. The bench drives every input on the falling edge and starts with two reset cycles. Apart from that, the assertions place no limit on the requests: a pseudo-random sweep drives requests in every state, including during busy states, and pulses reset in the middle of transactions. These inputs break the handshake contract on purpose, and the properties still have to hold under them.

// File: rtl/mem_hs_pkg.sv
package mem_hs_pkg;

  localparam int HS_NSTATES = 4;
  localparam int HS_SW      = $clog2(HS_NSTATES);

  typedef enum logic [HS_SW-1:0] {
    ST_IDLE = 2'd0,
    ST_WR_A = 2'd1,
    ST_WR_B = 2'd2,
    ST_RD   = 2'd3
  } hs_state_e;

  typedef struct packed {
    logic cap;
    logic rd_n_wr;
    logic done;
  } hs_out_t;

  localparam hs_out_t OUT_QUIET = '{cap: 1'b0, rd_n_wr: 1'b1, done: 1'b0};

  // Next state: reset first, then write before read while idle.
  function automatic hs_state_e hs_next(hs_state_e cur, logic rst, logic wr, logic rd);
    hs_state_e n;
    if (rst) begin
      n = ST_IDLE;
    end else begin
      unique case (cur)
        ST_IDLE: n = wr ? ST_WR_A : (rd ? ST_RD : ST_IDLE);
        ST_WR_A: n = ST_WR_B;
        ST_WR_B: n = ST_IDLE;
        default: n = ST_IDLE;
      endcase
    end
    return n;
  endfunction

  // Outputs: only the idle state looks at the request lines.
  function automatic hs_out_t hs_outs(hs_state_e cur, logic rst, logic wr, logic rd);
    hs_out_t o;
    o = OUT_QUIET;
    if (!rst) begin
      unique case (cur)
        ST_IDLE: o.cap = wr | rd;
        ST_WR_A: o = OUT_QUIET;
        ST_WR_B: begin o.rd_n_wr = 1'b0; o.done = 1'b1; end
        default: o.done = 1'b1;
      endcase
    end
    return o;
  endfunction

  function automatic logic [HS_NSTATES-1:0] hs_to_oh(hs_state_e s);
    logic [HS_NSTATES-1:0] v;
    v = '0;
    v[s] = 1'b1;
    return v;
  endfunction

  function automatic hs_state_e hs_from_oh(logic [HS_NSTATES-1:0] v);
    hs_state_e s;
    s = ST_IDLE;
    for (int i = 0; i < HS_NSTATES; i++) begin
      if (v[i]) s = hs_state_e'(HS_SW'(i));
    end
    return s;
  endfunction

endpackage

// File: rtl/mem_hs_next.sv
module mem_hs_next
  import mem_hs_pkg::*;
(
  input  hs_state_e cur,
  input  logic      rst,
  input  logic      wr,
  input  logic      rd,
  output hs_state_e nxt,
  output logic      start_wr,
  output logic      start_rd,
  output logic      txn_end
);

  logic is_idle;

  assign is_idle  = (cur == ST_IDLE);
  assign start_wr = !rst && is_idle && wr;
  assign start_rd = !rst && is_idle && !wr && rd;
  assign txn_end  = !rst && ((cur == ST_RD) || (cur == ST_WR_B));

  always_comb begin
    nxt = hs_next(cur, rst, wr, rd);
  end

endmodule

// File: rtl/mem_hs_outs.sv
module mem_hs_outs
  import mem_hs_pkg::*;
(
  input  hs_state_e cur,
  input  logic      rst,
  input  logic      wr,
  input  logic      rd,
  output hs_out_t   o
);

  always_comb begin
    o = hs_outs(cur, rst, wr, rd);
  end

endmodule

// File: rtl/mem_hs_streg.sv
module mem_hs_streg
  import mem_hs_pkg::*;
#(
  parameter bit ONE_HOT = 1'b0
) (
  input  logic      clk,
  input  logic      rst,
  input  hs_state_e d,
  output hs_state_e q
);

  generate
    if (ONE_HOT) begin : g_oh
      logic [HS_NSTATES-1:0] oh_q;
      always_ff @(posedge clk) begin
        oh_q <= hs_to_oh(d);
      end
      assign q = hs_from_oh(oh_q);

      AST_ONEHOT_STATE: assert property (@(posedge clk) disable iff (rst)
        $countones(oh_q) == 1); // R10
    end else begin : g_bin
      hs_state_e st_q;
      always_ff @(posedge clk) begin
        st_q <= d;
      end
      assign q = st_q;
    end
  endgenerate

endmodule

// File: rtl/mem_hs_ctl.sv
module mem_hs_ctl
  import mem_hs_pkg::*;
#(
  parameter bit ONE_HOT = 1'b0
) (
  input  logic clk,
  input  logic rst,
  input  logic req_wr,
  input  logic req_rd,
  output logic addr_cap,
  output logic rd_nwr,
  output logic done
);

  hs_state_e cur;
  hs_state_e nxt;
  hs_out_t   outs;
  logic      start_wr;
  logic      start_rd;
  logic      txn_end;

  mem_hs_next u_next (
    .cur      (cur),
    .rst      (rst),
    .wr       (req_wr),
    .rd       (req_rd),
    .nxt      (nxt),
    .start_wr (start_wr),
    .start_rd (start_rd),
    .txn_end  (txn_end)
  );

  mem_hs_streg #(.ONE_HOT(ONE_HOT)) u_reg (
    .clk (clk),
    .rst (rst),
    .d   (nxt),
    .q   (cur)
  );

  mem_hs_outs u_outs (
    .cur (cur),
    .rst (rst),
    .wr  (req_wr),
    .rd  (req_rd),
    .o   (outs)
  );

  assign addr_cap = outs.cap;
  assign rd_nwr   = outs.rd_n_wr;
  assign done     = outs.done;

  AST_RESET_TO_IDLE: assert property (@(posedge clk)
    rst |=> (cur == ST_IDLE)); // R2
  AST_WRITE_WINS: assert property (@(posedge clk) disable iff (rst)
    start_wr |=> (cur == ST_WR_A && !done && rd_nwr)); // R4
  AST_READ_ACK_NEXT: assert property (@(posedge clk) disable iff (rst)
    start_rd |=> (done && rd_nwr && !addr_cap)); // R5
  AST_WRITE_ACK_SECOND: assert property (@(posedge clk) disable iff (rst)
    (cur == ST_WR_A) |=> (done && !rd_nwr)); // R6
  AST_DIR_LOW_LAST_WR: assert property (@(posedge clk) disable iff (rst)
    !rd_nwr |-> $past(cur == ST_WR_A)); // R7
  AST_BUSY_NO_CAP: assert property (@(posedge clk) disable iff (rst)
    (cur != ST_IDLE) |-> !addr_cap); // R8
  AST_DONE_PULSE: assert property (@(posedge clk) disable iff (rst)
    done |=> !done); // R9
  AST_END_TO_IDLE: assert property (@(posedge clk) disable iff (rst)
    txn_end |=> (cur == ST_IDLE)); // R9

endmodule

// File: tb/sim_mem_hs_ctl.sv
`timescale 1ns/1ps
module sim_mem_hs_ctl;

  logic clk = 1'b0;
  always #2.5 clk = ~clk;

  logic rst = 1'b1, req_wr = 1'b0, req_rd = 1'b0;
  logic cap0, dir0, done0, cap1, dir1, done1;
  int   n_vec = 0, n_bad = 0;
  int   mst = 0; // 0 idle, 1 first write, 2 last write, 3 read

  mem_hs_ctl #(.ONE_HOT(1'b0)) u0 (.clk(clk), .rst(rst), .req_wr(req_wr), .req_rd(req_rd),
    .addr_cap(cap0), .rd_nwr(dir0), .done(done0));
  mem_hs_ctl #(.ONE_HOT(1'b1)) u1 (.clk(clk), .rst(rst), .req_wr(req_wr), .req_rd(req_rd),
    .addr_cap(cap1), .rd_nwr(dir1), .done(done1));

  // expected {addr_cap, rd_nwr, done}
  function automatic logic [2:0] ref_out(int s, logic r, logic w, logic d);
    if (r) return 3'b010;
    if (s == 0) return {w | d, 2'b10};
    if (s == 1) return 3'b010;
    if (s == 2) return 3'b001;
    return 3'b011;
  endfunction

  function automatic int ref_next(int s, logic r, logic w, logic d);
    if (r) return 0;
    if (s == 0) return w ? 1 : (d ? 3 : 0);
    if (s == 1) return 2;
    return 0;
  endfunction

  always @(posedge clk) mst <= ref_next(mst, rst, req_wr, req_rd);

  task automatic chk(string tag, logic [2:0] act, logic [2:0] exp);
    n_vec++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%b expected=%b (state %0d)", tag, act, exp, mst);
    end
  endtask

  task automatic chk_int(string tag, int act, int exp);
    n_vec++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic cmp_all(string tag);
    logic [2:0] e;
    e = ref_out(mst, rst, req_wr, req_rd);
    chk(tag, {cap0, dir0, done0}, e);
    chk("R10", {cap1, dir1, done1}, e);
  endtask

  function automatic string pick_tag();
    if (rst) return "R2";
    case (mst)
      0: return req_wr ? "R4" : (req_rd ? "R5" : "R3");
      1: return (req_wr | req_rd) ? "R8" : "R6";
      2: return "R7";
      default: return (req_wr | req_rd) ? "R8" : "R5";
    endcase
  endfunction

  task automatic run_txn(logic w, logic d, int want, string tag);
    int  lat = 0;
    bit  seen = 0;
    @(negedge clk);
    req_wr = w; req_rd = d;
    for (int k = 0; k < 6 && !seen; k++) begin
      #1;
      lat++;
      cmp_all(tag);
      if (done0) seen = 1;
      else @(negedge clk);
    end
    req_wr = 1'b0; req_rd = 1'b0;
    chk_int("R9 latency", lat, want);
  endtask

  initial begin
    #(200000 * 5);
    n_bad++;
    $display("FAIL watchdog R9 actual=timeout expected=completion");
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end

  initial begin
    logic [15:0] lf;
    repeat (2) @(negedge clk);
    req_wr = 1'b1; req_rd = 1'b1;
    #1 cmp_all("R2");
    @(negedge clk);
    rst = 1'b0; req_wr = 1'b0; req_rd = 1'b0;
    #1 cmp_all("R1");
    repeat (3) begin
      @(negedge clk);
      #1 cmp_all("R3");
    end
    run_txn(1'b0, 1'b1, 2, "R5");
    run_txn(1'b1, 1'b0, 3, "R6");
    run_txn(1'b1, 1'b1, 3, "R4");
    // busy cycles with stray requests (R8)
    @(negedge clk);
    req_wr = 1'b1; req_rd = 1'b0;
    #1 cmp_all("R4");
    @(negedge clk);
    req_wr = 1'b0; req_rd = 1'b1;
    #1 cmp_all("R8");
    @(negedge clk);
    req_wr = 1'b1; req_rd = 1'b1;
    #1 cmp_all("R8");
    chk("R7", {1'b0, dir0, 1'b0}, 3'b000);
    @(negedge clk);
    req_wr = 1'b0; req_rd = 1'b0;
    #1 cmp_all("R3");
    // reset in the middle of a read
    @(negedge clk);
    req_rd = 1'b1;
    @(negedge clk);
    rst = 1'b1;
    #1 cmp_all("R2");
    @(negedge clk);
    rst = 1'b0; req_rd = 1'b0;
    #1 cmp_all("R2");
    // pseudo-random sweep over states and input combinations
    lf = 16'hACE1;
    for (int i = 0; i < 4000; i++) begin
      @(negedge clk);
      lf = {lf[14:0], lf[15] ^ lf[13] ^ lf[12] ^ lf[10]};
      rst    = (lf[2:0] == 3'd0);
      req_wr = lf[5];
      req_rd = lf[9];
      #1 cmp_all(pick_tag());
    end
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end

endmodule